// File: doc/BRIEF.md
# DRAM Read-Latency and Power-Down Exit Timer

This block sits on the controller side of a DDR3-style memory interface and keeps a local copy of the first mode-register word. From that copy it decodes two settings. The first is the read latency in whole clocks. The second is whether the DLL keeps running while the device is in precharge power-down. The controller pulses `rd_cmd` for one clock for each read it issues. The block answers with a `rd_valid` window that opens exactly the programmed latency later and stays open for one burst. Reads may overlap in flight, so several can sit in the pipeline at the same time.

The block also follows the device into and out of precharge power-down. After an exit request, `cmd_ready` stays low for an exit delay given in clocks. That delay comes from one of two inputs, and the DLL policy bit of the stored word picks which one. A read that arrives while the device is not ready, or that comes too close to the previous accepted read, is dropped and reported. A mode-word write is refused while reads are in flight or the device is not ready. A latency code outside the legal range is refused and latched as a configuration error.

Top module: `dram_rdlat_pdx_timer`

## Requirements
- R1: After reset, `rd_valid`, `in_pd`, `cfg_err`, `mr_reject` and `proto_viol` are 0, `cmd_ready` is 1, and `mr_q` holds 16'h0010 (latency code 3'b001, DLL bit 0).
- R2: The latency field is `mr_q[6:4]`. Codes 3'b001 through 3'b110 give latencies of 5, 6, 7, 8, 9 and 10 clocks (code + 4). A legal write is visible on `mr_q` one clock after the write edge.
- R3: A read accepted at clock edge n drives `rd_valid` high after edges n+CL through n+CL+3, which is 4 clocks for a burst of 8.
- R4: Reads accepted exactly 4 clocks apart give one continuous `rd_valid` window with no gap and no `proto_viol`.
- R5: A `rd_cmd` that comes fewer than 4 clocks after the previous accepted read is dropped. It adds no `rd_valid` clocks, and `proto_viol` pulses for one clock after that edge.
- R6: A write whose latency code is 3'b000 or 3'b111 leaves `mr_q` unchanged and sets `cfg_err`. `cfg_err` then stays 1 until reset.
- R7: A write to the mode word is refused when a read is in flight, when `rd_cmd` is accepted on the same edge, or when `cmd_ready` is 0. A refused write leaves `mr_q` unchanged and pulses `mr_reject` for one clock.
- R8: `pd_enter` while `cmd_ready` is 1 sets `in_pd` to 1 and `cmd_ready` to 0 on the next clock.
- R9: With `mr_q[12]` = 0, a `pd_exit` in power-down at edge e clears `in_pd`. `cmd_ready` then rises after edge e+max(`txpdll_cycles`,1).
- R10: With `mr_q[12]` = 1, the same exit uses `txp_cycles` in place of `txpdll_cycles`.
- R11: A `rd_cmd` while `cmd_ready` is 0 (in power-down or during the exit wait) is dropped. It produces no `rd_valid`, and `proto_viol` pulses for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mr_wr | input | 1 | Mode-word write strobe |
| mr_wdata | input | 16 | Mode word to store |
| rd_cmd | input | 1 | One-clock read command strobe |
| pd_enter | input | 1 | Enter precharge power-down |
| pd_exit | input | 1 | Request exit from power-down |
| txp_cycles | input | 8 | Exit delay used when the DLL keeps running |
| txpdll_cycles | input | 8 | Exit delay used when the DLL is stopped |
| rd_valid | output | 1 | Read data window |
| cmd_ready | output | 1 | Device can take commands |
| in_pd | output | 1 | Device is in power-down |
| mr_q | output | 16 | Stored mode word |
| cfg_err | output | 1 | Sticky illegal-latency flag |
| mr_reject | output | 1 | Pulse: mode write refused |
| proto_viol | output | 1 | Pulse: read command dropped |

## Verification
`rd_valid` for a read sampled at edge n is due after edges n+CL to n+CL+3. `mr_q`, `cfg_err`, `mr_reject`, `proto_viol` and `in_pd` each respond one edge after their stimulus. `cmd_ready` rises max(T,1) edges after the exit request. The bench numbers every edge it drives. It drives inputs on the falling edge and reads outputs on the next falling edge, after the edge it is checking. A scoreboard indexed by edge number records when each random read is due and the exact edge at which each exit window ends. Each observed value is compared against the entry for that edge.

// File: rtl/dram_tmr_pkg.sv
package dram_tmr_pkg;

   localparam int CL_W = 4;

   typedef enum logic [1:0] {
      PDX_ACTIVE = 2'd0,
      PDX_ASLEEP = 2'd1,
      PDX_WAKING = 2'd2
   } pdx_state_e;

   function automatic logic cl_code_ok(input logic [2:0] code);
      return (code != 3'b000) && (code != 3'b111);
   endfunction

   function automatic logic [CL_W-1:0] cl_from_code(input logic [2:0] code);
      return CL_W'(code) + CL_W'(4);
   endfunction

endpackage

// File: rtl/dram_tmr_mr_shadow.sv
module dram_tmr_mr_shadow
   import dram_tmr_pkg::*;
#(
   parameter int MR_W    = 16,
   parameter int CL_LSB  = 4,
   parameter int DLL_BIT = 12,
   parameter logic [MR_W-1:0] MR_RESET = 16'h0010
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_req,
   input  logic [MR_W-1:0] wr_word,
   input  logic            blocked,
   output logic [MR_W-1:0] word_q,
   output logic [CL_W-1:0] cl_clocks,
   output logic            dll_run,
   output logic            bad_code,
   output logic            wr_rej
);

   logic [2:0] new_code;
   logic       code_legal;

   assign new_code   = wr_word[CL_LSB +: 3];
   assign code_legal = cl_code_ok(new_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= MR_RESET;
         bad_code <= 1'b0;
         wr_rej   <= 1'b0;
      end else begin
         wr_rej <= 1'b0;
         if (wr_req) begin
            if (blocked) begin
               wr_rej <= 1'b1;
            end else if (!code_legal) begin
               bad_code <= 1'b1;
            end else begin
               word_q <= wr_word;
            end
         end
      end
   end

   assign cl_clocks = cl_from_code(word_q[CL_LSB +: 3]);
   assign dll_run   = word_q[DLL_BIT];

endmodule

// File: rtl/dram_tmr_rd_pipe.sv
module dram_tmr_rd_pipe
   import dram_tmr_pkg::*;
#(
   parameter int CL_MAX      = 10,
   parameter int BURST_BEATS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic [CL_W-1:0] cl_clocks,
   output logic            rd_valid,
   output logic            spacing_ok,
   output logic            busy
);

   logic [CL_MAX-1:0] stage_q;
   logic [CL_MAX-1:0] tap_hit;
   logic              launch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[CL_MAX-2:0], accept};
   end

   // stage k holds a read accepted k+1 edges ago
   for (genvar k = 0; k < CL_MAX; k++) begin : g_tap
      assign tap_hit[k] = stage_q[k] & (cl_clocks == CL_W'(k + 1));
   end

   assign launch = |tap_hit;

   if (BURST_BEATS == 1) begin : g_single
      logic valid_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) valid_q <= 1'b0;
         else        valid_q <= launch;
      end
      assign rd_valid   = valid_q;
      assign spacing_ok = 1'b1;
   end else begin : g_count
      localparam int BW = $clog2(BURST_BEATS + 1);
      localparam int GW = $clog2(BURST_BEATS);
      logic [BW-1:0] beat_q;
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            beat_q <= '0;
            gap_q  <= '0;
         end else begin
            if (launch)              beat_q <= BW'(BURST_BEATS);
            else if (beat_q != '0)   beat_q <= beat_q - 1'b1;
            if (accept)              gap_q  <= GW'(BURST_BEATS - 1);
            else if (gap_q != '0)    gap_q  <= gap_q - 1'b1;
         end
      end
      assign rd_valid   = (beat_q != '0);
      assign spacing_ok = (gap_q == '0);
   end

   assign busy = (|stage_q) | rd_valid;

endmodule

// File: rtl/dram_tmr_pdx_fsm.sv
module dram_tmr_pdx_fsm
   import dram_tmr_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enter,
   input  logic          leave,
   input  logic          dll_run,
   input  logic [TW-1:0] t_fast,
   input  logic [TW-1:0] t_slow,
   output logic          ready,
   output logic          asleep
);

   pdx_state_e    state_q;
   logic [TW-1:0] wait_q;
   logic [TW-1:0] wait_sel;

   assign wait_sel = dll_run ? t_fast : t_slow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PDX_ACTIVE;
         wait_q  <= '0;
      end else begin
         unique case (state_q)
            PDX_ACTIVE: if (enter) state_q <= PDX_ASLEEP;
            PDX_ASLEEP: if (leave) begin
               state_q <= PDX_WAKING;
               wait_q  <= wait_sel;
            end
            PDX_WAKING: begin
               if (wait_q <= TW'(1)) begin
                  state_q <= PDX_ACTIVE;
                  wait_q  <= '0;
               end else begin
                  wait_q <= wait_q - 1'b1;
               end
            end
            default: state_q <= PDX_ACTIVE;
         endcase
      end
   end

   assign ready  = (state_q == PDX_ACTIVE);
   assign asleep = (state_q == PDX_ASLEEP);

endmodule

// File: rtl/dram_rdlat_pdx_timer.sv
module dram_rdlat_pdx_timer
   import dram_tmr_pkg::*;
#(
   parameter int MR_W        = 16,
   parameter int CL_LSB      = 4,
   parameter int DLL_BIT     = 12,
   parameter int CL_MAX      = 10,
   parameter int BURST_BEATS = 4,
   parameter int TW          = 8,
   parameter logic [MR_W-1:0] MR_RESET = 16'h0010
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mr_wr,
   input  logic [MR_W-1:0] mr_wdata,
   input  logic            rd_cmd,
   input  logic            pd_enter,
   input  logic            pd_exit,
   input  logic [TW-1:0]   txp_cycles,
   input  logic [TW-1:0]   txpdll_cycles,
   output logic            rd_valid,
   output logic            cmd_ready,
   output logic            in_pd,
   output logic [MR_W-1:0] mr_q,
   output logic            cfg_err,
   output logic            mr_reject,
   output logic            proto_viol
);

   if (MR_W <= DLL_BIT || MR_W < CL_LSB + 3) begin : g_bad_mr
      $error("mode word too narrow for its fields");
   end
   if (CL_MAX != 10) begin : g_bad_cl
      $error("pipeline depth must cover the largest latency of 10");
   end
   if (BURST_BEATS < 1 || BURST_BEATS > 8) begin : g_bad_bl
      $error("burst length in clocks out of range");
   end
   if (TW < 6) begin : g_bad_tw
      $error("exit delay inputs need at least 6 bits");
   end
   if (MR_RESET[CL_LSB +: 3] == 3'b000 || MR_RESET[CL_LSB +: 3] == 3'b111) begin : g_bad_rst
      $error("reset mode word carries an illegal latency code");
   end

   logic [CL_W-1:0] cl_clocks;
   logic            dll_run;
   logic            spacing_ok;
   logic            rd_busy;
   logic            rd_accept;
   logic            mr_blocked;
   logic            viol_q;

   assign rd_accept  = rd_cmd & cmd_ready & spacing_ok;
   assign mr_blocked = rd_busy | rd_accept | ~cmd_ready;

   dram_tmr_mr_shadow #(
      .MR_W     (MR_W),
      .CL_LSB   (CL_LSB),
      .DLL_BIT  (DLL_BIT),
      .MR_RESET (MR_RESET)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (mr_wr),
      .wr_word   (mr_wdata),
      .blocked   (mr_blocked),
      .word_q    (mr_q),
      .cl_clocks (cl_clocks),
      .dll_run   (dll_run),
      .bad_code  (cfg_err),
      .wr_rej    (mr_reject)
   );

   dram_tmr_rd_pipe #(
      .CL_MAX      (CL_MAX),
      .BURST_BEATS (BURST_BEATS)
   ) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (rd_accept),
      .cl_clocks  (cl_clocks),
      .rd_valid   (rd_valid),
      .spacing_ok (spacing_ok),
      .busy       (rd_busy)
   );

   dram_tmr_pdx_fsm #(
      .TW (TW)
   ) u_pdx (
      .clk     (clk),
      .rst_n   (rst_n),
      .enter   (pd_enter),
      .leave   (pd_exit),
      .dll_run (dll_run),
      .t_fast  (txp_cycles),
      .t_slow  (txpdll_cycles),
      .ready   (cmd_ready),
      .asleep  (in_pd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) viol_q <= 1'b0;
      else        viol_q <= rd_cmd & ~rd_accept;
   end

   assign proto_viol = viol_q;

endmodule

// File: rtl/dram_rdlat_pdx_timer_chk.sv
module dram_rdlat_pdx_timer_chk #(
   parameter int MR_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_cmd,
   input logic            pd_enter,
   input logic            pd_exit,
   input logic            cmd_ready,
   input logic            in_pd,
   input logic [MR_W-1:0] mr_q,
   input logic            cfg_err,
   input logic            mr_reject,
   input logic            proto_viol
);

   assert_ready_not_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !in_pd);

   assert_enter_sleeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && pd_enter) |=> in_pd);

   assert_cfg_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   assert_reject_keeps_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mr_reject |-> $stable(mr_q));

   assert_drop_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && !cmd_ready) |=> proto_viol);

   assert_viol_needs_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      proto_viol |-> $past(rd_cmd));

   assert_exit_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pd && pd_exit) |=> (!cmd_ready && !in_pd));

endmodule

bind dram_rdlat_pdx_timer dram_rdlat_pdx_timer_chk #(.MR_W(MR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_cmd     (rd_cmd),
   .pd_enter   (pd_enter),
   .pd_exit    (pd_exit),
   .cmd_ready  (cmd_ready),
   .in_pd      (in_pd),
   .mr_q       (mr_q),
   .cfg_err    (cfg_err),
   .mr_reject  (mr_reject),
   .proto_viol (proto_viol)
);

// File: tb/dram_rdlat_pdx_timer_tb.sv
module dram_rdlat_pdx_timer_tb;

   localparam int CLK_P = 10;
   localparam int MASK  = 1023;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mr_wr = 1'b0;
   logic [15:0] mr_wdata = '0;
   logic        rd_cmd = 1'b0;
   logic        pd_enter = 1'b0;
   logic        pd_exit = 1'b0;
   logic [7:0]  txp_cycles = 8'd3;
   logic [7:0]  txpdll_cycles = 8'd9;
   logic        rd_valid, cmd_ready, in_pd, cfg_err, mr_reject, proto_viol;
   logic [15:0] mr_q;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit exp_v [0:MASK];
   bit exp_p [0:MASK];

   always #(CLK_P/2) clk = ~clk;

   dram_rdlat_pdx_timer u_dut (
      .clk(clk), .rst_n(rst_n), .mr_wr(mr_wr), .mr_wdata(mr_wdata),
      .rd_cmd(rd_cmd), .pd_enter(pd_enter), .pd_exit(pd_exit),
      .txp_cycles(txp_cycles), .txpdll_cycles(txpdll_cycles),
      .rd_valid(rd_valid), .cmd_ready(cmd_ready), .in_pd(in_pd),
      .mr_q(mr_q), .cfg_err(cfg_err), .mr_reject(mr_reject),
      .proto_viol(proto_viol)
   );

   function automatic logic [15:0] mk_mr(input bit dll, input int code);
      return (16'(dll) << 12) | (16'(code & 7) << 4);
   endfunction

   function automatic int exit_due(input int t);
      return (t < 1) ? 1 : t;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, cyc);
      end
   endtask

   // one edge; inputs are set before the call, outputs read after it
   task automatic tick();
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic mr_write(input logic [15:0] w);
      mr_wr = 1'b1; mr_wdata = w;
      tick();
      mr_wr = 1'b0;
   endtask

   // reads at given offsets from the first edge; reports the valid window
   task automatic burst_run(input int o1, input int o2, input int o3, input int len,
                            output int n, output int first, output int last,
                            output int cnt, output int pv);
      first = -1; last = -1; cnt = 0; pv = 0; n = cyc + 1;
      for (int i = 0; i < len; i++) begin
         rd_cmd = (i == o1) || (i == o2) || (i == o3);
         tick();
         rd_cmd = 1'b0;
         if (rd_valid) begin
            if (first < 0) first = cyc;
            last = cyc;
            cnt++;
         end
         if (proto_viol) pv++;
      end
   endtask

   task automatic scb_tick(input bit rd, input int cl, inout int lastacc);
      rd_cmd = rd;
      tick();
      rd_cmd = 1'b0;
      if (rd) begin
         if (lastacc < 0 || cyc - lastacc >= 4) begin
            for (int k = 0; k < 4; k++) exp_v[(cyc + cl + k) & MASK] = 1'b1;
            lastacc = cyc;
         end else begin
            exp_p[cyc & MASK] = 1'b1;
         end
      end
      chk("R3/R4 random rd_valid", 32'(rd_valid), 32'(exp_v[cyc & MASK]));
      chk("R5 random proto_viol", 32'(proto_viol), 32'(exp_p[cyc & MASK]));
      exp_v[cyc & MASK] = 1'b0;
      exp_p[cyc & MASK] = 1'b0;
   endtask

   initial begin : wdog
      #(CLK_P * 200000);
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin : main
      int n, first, last, cnt, pv, e, lastacc;
      logic [15:0] keep;
      void'($urandom(32'd20240607));
      for (int i = 0; i <= MASK; i++) begin exp_v[i] = 1'b0; exp_p[i] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rd_valid", 32'(rd_valid), 0);
      chk("R1 cmd_ready", 32'(cmd_ready), 1);
      chk("R1 in_pd", 32'(in_pd), 0);
      chk("R1 cfg_err", 32'(cfg_err), 0);
      chk("R1 mr_reject", 32'(mr_reject), 0);
      chk("R1 proto_viol", 32'(proto_viol), 0);
      chk("R1 mr_q", 32'(mr_q), 32'h0010);

      // R2 R3: every legal latency code
      for (int code = 1; code <= 6; code++) begin
         mr_write(mk_mr(1'b0, code));
         chk("R2 mr_q after write", 32'(mr_q), 32'(mk_mr(1'b0, code)));
         chk("R2 no reject when idle", 32'(mr_reject), 0);
         burst_run(0, -1, -1, code + 4 + 8, n, first, last, cnt, pv);
         chk("R2/R3 first valid edge", 32'(first), 32'(n + code + 4));
         chk("R3 window length", 32'(cnt), 4);
      end

      // R4 back-to-back reads 4 apart, CL 7
      mr_write(mk_mr(1'b0, 3));
      burst_run(0, 4, 8, 24, n, first, last, cnt, pv);
      chk("R4 first edge", 32'(first), 32'(n + 7));
      chk("R4 last edge", 32'(last), 32'(n + 18));
      chk("R4 continuous count", 32'(cnt), 12);
      chk("R4 no violation", 32'(pv), 0);

      // R5 read 2 clocks after an accepted read is dropped
      burst_run(0, 2, -1, 20, n, first, last, cnt, pv);
      chk("R5 only one burst", 32'(cnt), 4);
      chk("R5 first edge", 32'(first), 32'(n + 7));
      chk("R5 one violation", 32'(pv), 1);

      // R6 illegal codes
      keep = mr_q;
      mr_write(mk_mr(1'b1, 0));
      chk("R6 code 0 word kept", 32'(mr_q), 32'(keep));
      chk("R6 code 0 sets err", 32'(cfg_err), 1);
      mr_write(mk_mr(1'b1, 7));
      chk("R6 code 7 word kept", 32'(mr_q), 32'(keep));
      mr_write(mk_mr(1'b0, 2));
      chk("R6 legal write after error", 32'(mr_q), 32'(mk_mr(1'b0, 2)));
      chk("R6 err sticky", 32'(cfg_err), 1);

      // R7 write refused while a read is in flight
      keep = mr_q;
      rd_cmd = 1'b1; tick(); rd_cmd = 1'b0;
      tick();
      mr_write(mk_mr(1'b0, 5));
      chk("R7 in-flight reject pulse", 32'(mr_reject), 1);
      chk("R7 in-flight word kept", 32'(mr_q), 32'(keep));
      tick();
      chk("R7 reject is one clock", 32'(mr_reject), 0);
      repeat (16) tick();
      // R7 write on same edge as accepted read
      rd_cmd = 1'b1; mr_wr = 1'b1; mr_wdata = mk_mr(1'b0, 4);
      tick();
      rd_cmd = 1'b0; mr_wr = 1'b0;
      chk("R7 same-edge reject", 32'(mr_reject), 1);
      chk("R7 same-edge word kept", 32'(mr_q), 32'(keep));
      repeat (16) tick();

      // R8 enter power-down
      pd_enter = 1'b1; tick(); pd_enter = 1'b0;
      chk("R8 in_pd", 32'(in_pd), 1);
      chk("R8 cmd_ready low", 32'(cmd_ready), 0);
      mr_write(mk_mr(1'b1, 2));
      chk("R7 reject in power-down", 32'(mr_reject), 1);
      chk("R7 word kept in power-down", 32'(mr_q), 32'(keep));
      // R11 read while asleep
      burst_run(0, -1, -1, 16, n, first, last, cnt, pv);
      chk("R11 no valid when asleep", 32'(cnt), 0);
      chk("R11 violation when asleep", 32'(pv), 1);

      // R9 exit with DLL stopped uses txpdll (9)
      pd_exit = 1'b1; tick(); pd_exit = 1'b0;
      e = cyc;
      chk("R9 left power-down", 32'(in_pd), 0);
      chk("R9 not ready at exit", 32'(cmd_ready), 0);
      while (cyc < e + exit_due(32'(txpdll_cycles)) - 1) begin
         rd_cmd = (cyc == e + 1);
         tick();
         if (rd_cmd) chk("R11 read during exit wait flagged", 32'(proto_viol), 1);
         rd_cmd = 1'b0;
         chk("R9 still waiting", 32'(cmd_ready), 0);
      end
      tick();
      chk("R9 ready after txpdll", 32'(cmd_ready), 1);
      chk("R11 dropped read gave no data", 32'(rd_valid), 0);

      // R10 exit with DLL running uses txp (3)
      mr_write(mk_mr(1'b1, 1));
      chk("R10 word with dll bit", 32'(mr_q), 32'(mk_mr(1'b1, 1)));
      pd_enter = 1'b1; tick(); pd_enter = 1'b0;
      pd_exit = 1'b1; tick(); pd_exit = 1'b0;
      e = cyc;
      tick(); tick();
      chk("R10 waiting at e+2", 32'(cmd_ready), 0);
      tick();
      chk("R10 ready at e+3", 32'(cmd_ready), 1);

      // R10 zero delay still takes one clock
      txp_cycles = 8'd0;
      pd_enter = 1'b1; tick(); pd_enter = 1'b0;
      pd_exit = 1'b1; tick(); pd_exit = 1'b0;
      chk("R10 zero delay low at exit edge", 32'(cmd_ready), 0);
      tick();
      chk("R10 zero delay ready next edge", 32'(cmd_ready), 1);
      txp_cycles = 8'd3;

      // random reads against a scoreboard
      for (int r = 0; r < 4; r++) begin
         int code;
         code = int'($urandom_range(1, 6));
         mr_write(mk_mr(r[0], code));
         chk("R2 random write", 32'(mr_q), 32'(mk_mr(r[0], code)));
         lastacc = -1;
         for (int i = 0; i < 150; i++)
            scb_tick(($urandom_range(0, 2) == 0), code + 4, lastacc);
         for (int i = 0; i < 20; i++)
            scb_tick(1'b0, code + 4, lastacc);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule